// File: doc/BRIEF.md
# Bridge Memory Window Forwarding Decoder

This block sits beside a bus-to-bus bridge. For each memory transaction it decides whether the bridge should claim it and, if so, which way to pass it. It holds three address ranges. The first is a prefetchable window with 64-bit bounds. The second is a 32-bit window for non-prefetchable memory-mapped I/O. The third is the fixed legacy display range 0xA0000–0xBFFFF, which has its own enable. Software loads these through a small register write port.

The answer depends on the side the transaction came from. A request from the upstream side is claimed when it hits any range, and it is then sent downstream. A request from the downstream side is claimed only when it misses every range, and it is then sent upstream. Both windows use 1 MB granularity with an inclusive limit. A single-address-cycle request is compared as a 64-bit address whose upper 32 bits are zero. The block also raises a prefetch-allowed flag for reads that hit the prefetchable window.

Top module: `mwin_fwd_decode`

## Requirements
- R1: A memory command (class 01, 10 or 11) from the upstream side (fromDown=0) that hits the prefetchable window gives claim=1 and fwdUp=0.
- R2: A memory command from the downstream side (fromDown=1) that hits the prefetchable window gives claim=0 and fwdUp=0.
- R3: A memory command from the upstream side that misses the prefetchable window, the I/O window and the enabled display range gives claim=0.
- R4: A memory command from the downstream side that misses all ranges gives claim=1 and fwdUp=1. A hit in the I/O window or in the enabled display range instead gives claim=0.
- R5: When dualCycle=1, all 64 address bits are compared against the window. Register 1 holds the upper base and register 3 holds the upper limit of the prefetchable window.
- R6: When dualCycle=0, address bits 63:32 are treated as zero. Such a request can hit the prefetchable window only when the upper base register is zero.
- R7: prefetchOk=1 exactly for a read class (10 or 11) from the upstream side that hits the prefetchable window. A write (class 01) that hits the same window gives prefetchOk=0.
- R8: Only address bits above bit 19 are compared. The limit is inclusive, with bits 19:0 taken as ones. The lower-word registers (0 prefetch base, 2 prefetch limit, 4 I/O base, 5 I/O limit) keep only write data bits 31:20.
- R9: A window whose base is above its limit never hits.
- R10: An upstream hit in the I/O window, or in 0xA0000–0xBFFFF while register 6 bit 0 is set, gives claim=1, fwdUp=0 and prefetchOk=0.
- R11: Command class 00 (not a memory command) is never claimed.
- R12: The outputs are registered. decValid is 1 in the cycle after an addrValid strobe and 0 otherwise, and claim, fwdUp and prefetchOk are 0 while decValid is 0. A register write applies from the next strobe on; a strobe in the same cycle as the write still sees the old value.
- R13: After reset, all outputs are 0, both windows are disabled and the display range is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register index (0..6) |
| wrData | input | DATA_W | Register write data |
| addrValid | input | 1 | Address strobe: evaluate this cycle's request |
| addr | input | 2*DATA_W | Transaction address |
| dualCycle | input | 1 | 1 = 64-bit dual-cycle address, 0 = single cycle |
| cmdClass | input | 2 | 00 other, 01 mem write, 10 mem read, 11 mem read block |
| fromDown | input | 1 | 1 = request seen on the downstream side |
| decValid | output | 1 | Decision valid |
| claim | output | 1 | Claim and forward the request |
| fwdUp | output | 1 | Forward direction: 1 upstream, 0 downstream |
| prefetchOk | output | 1 | Prefetching is allowed for this request |

## Verification
The bench builds the block with its default parameters, DATA_W=32 and GRAN_BITS=20. These give full 64-bit addresses, so the upper-half bound registers can be tested for real, along with masking of junk upper bits on single-cycle requests. The 1 MB boundaries fall on realistic addresses such as 0x80FF_FFFF and 0x8100_0000. Because the I/O window is narrow, the display range at 0xA0000 lies outside both windows, so it can be tested on its own.

// File: rtl/mwin_pkg.sv
package mwin_pkg;
  typedef enum logic [1:0] {
    CMD_OTHER   = 2'b00,
    CMD_MWR     = 2'b01,
    CMD_MRD     = 2'b10,
    CMD_MRD_BLK = 2'b11
  } cmdClass_e;

  localparam int NUM_REGS = 7;
  localparam int SEL_W    = 3;

  localparam int REG_PF_BASE_LO = 0;
  localparam int REG_PF_BASE_HI = 1;
  localparam int REG_PF_LIM_LO  = 2;
  localparam int REG_PF_LIM_HI  = 3;
  localparam int REG_IO_BASE    = 4;
  localparam int REG_IO_LIM     = 5;
  localparam int REG_CTRL       = 6;

  typedef struct packed {
    logic [NUM_REGS-1:0] load;
    logic                sample;
  } ctlStrobe_t;
endpackage

// File: rtl/mwin_range.sv
module mwin_range #(
  parameter int W = 44
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] a,
  output logic         hit
);
  assign hit = (a >= lo) && (a <= hi);

  always_comb begin
    if (hit) begin
      // R9
      range_order_chk: assert (lo <= hi);
    end
  end
endmodule

// File: rtl/mwin_ctrl.sv
module mwin_ctrl
  import mwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             addrValid,
  output ctlStrobe_t       strobe,
  output logic             decValid
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_load
    assign strobe.load[i] = wrEn && (wrSel == SEL_W'(i));
  end
  assign strobe.sample = addrValid;

  always_ff @(posedge clk) begin
    if (!rst_n) decValid <= 1'b0;
    else        decValid <= addrValid;
  end

  always_comb begin
    load_onehot_chk: assert ($onehot0(strobe.load));
  end

  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addrValid |=> decValid);

  // R12
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addrValid |=> !decValid);
endmodule

// File: rtl/mwin_dpath.sv
module mwin_dpath
  import mwin_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int GRAN_BITS = 20,
  localparam int ADDR_W   = 2 * DATA_W,
  localparam int LO_W     = DATA_W - GRAN_BITS,
  localparam int CMP_W    = ADDR_W - GRAN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dualCycle,
  input  logic [1:0]        cmdClass,
  input  logic              fromDown,
  output logic              claim,
  output logic              fwdUp,
  output logic              prefetchOk
);
  localparam logic [ADDR_W-1:0] VGA_LO = ADDR_W'(20'hA0000);
  localparam logic [ADDR_W-1:0] VGA_HI = ADDR_W'(20'hBFFFF);

  logic [DATA_W-1:0] pfBaseHi, pfLimHi;
  logic [LO_W-1:0]   pfBaseLo, pfLimLo, ioBase, ioLim;
  logic              vgaEn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfBaseHi <= '1;
      pfBaseLo <= '1;
      pfLimHi  <= '0;
      pfLimLo  <= '0;
      ioBase   <= '1;
      ioLim    <= '0;
      vgaEn    <= 1'b0;
    end else begin
      if (strobe.load[REG_PF_BASE_LO]) pfBaseLo <= wrData[DATA_W-1:GRAN_BITS];
      if (strobe.load[REG_PF_BASE_HI]) pfBaseHi <= wrData;
      if (strobe.load[REG_PF_LIM_LO])  pfLimLo  <= wrData[DATA_W-1:GRAN_BITS];
      if (strobe.load[REG_PF_LIM_HI])  pfLimHi  <= wrData;
      if (strobe.load[REG_IO_BASE])    ioBase   <= wrData[DATA_W-1:GRAN_BITS];
      if (strobe.load[REG_IO_LIM])     ioLim    <= wrData[DATA_W-1:GRAN_BITS];
      if (strobe.load[REG_CTRL])       vgaEn    <= wrData[0];
    end
  end

  logic [ADDR_W-1:0] effAddr;
  logic [CMP_W-1:0]  cmpAddr;
  assign effAddr = dualCycle ? addr : {{DATA_W{1'b0}}, addr[DATA_W-1:0]};
  assign cmpAddr = effAddr[ADDR_W-1:GRAN_BITS];

  logic [CMP_W-1:0] winLo [2];
  logic [CMP_W-1:0] winHi [2];
  logic [1:0]       winHit;
  assign winLo[0] = {pfBaseHi, pfBaseLo};
  assign winHi[0] = {pfLimHi, pfLimLo};
  assign winLo[1] = {{DATA_W{1'b0}}, ioBase};
  assign winHi[1] = {{DATA_W{1'b0}}, ioLim};

  for (genvar w = 0; w < 2; w++) begin : g_win
    mwin_range #(.W(CMP_W)) range_i (
      .lo (winLo[w]),
      .hi (winHi[w]),
      .a  (cmpAddr),
      .hit(winHit[w])
    );
  end

  logic pfHit, ioHit, vgaHit, anyHit, isMem, isRead;
  cmdClass_e cmd;
  assign cmd    = cmdClass_e'(cmdClass);
  assign pfHit  = winHit[0];
  assign ioHit  = winHit[1];
  assign vgaHit = vgaEn && (effAddr >= VGA_LO) && (effAddr <= VGA_HI);
  assign anyHit = pfHit || ioHit || vgaHit;
  assign isMem  = (cmd != CMD_OTHER);
  assign isRead = (cmd == CMD_MRD) || (cmd == CMD_MRD_BLK);

  logic nxtClaim, nxtUp, nxtPf;
  always_comb begin
    nxtClaim = 1'b0;
    nxtUp    = 1'b0;
    nxtPf    = 1'b0;
    if (isMem) begin
      if (fromDown) begin
        nxtClaim = !anyHit;
        nxtUp    = !anyHit;
      end else begin
        nxtClaim = anyHit;
        nxtPf    = pfHit && isRead;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !strobe.sample) begin
      claim      <= 1'b0;
      fwdUp      <= 1'b0;
      prefetchOk <= 1'b0;
    end else begin
      claim      <= nxtClaim;
      fwdUp      <= nxtUp;
      prefetchOk <= nxtPf;
    end
  end

  always_comb begin
    if (pfHit && !dualCycle) begin
      // R6
      single_upper_zero_chk: assert (pfBaseHi == '0);
    end
  end

  // R2
  down_pf_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.sample && fromDown && pfHit) |=> !claim);

  // R7
  prefetch_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prefetchOk |-> (claim && !fwdUp));

  // R11
  non_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.sample && cmd == CMD_OTHER) |=> !claim);

  // R10
  io_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.sample && isMem && !fromDown && ioHit && !pfHit) |=>
      (claim && !fwdUp && !prefetchOk));
endmodule

// File: rtl/mwin_fwd_decode.sv
module mwin_fwd_decode
  import mwin_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int GRAN_BITS = 20,
  localparam int ADDR_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dualCycle,
  input  logic [1:0]        cmdClass,
  input  logic              fromDown,
  output logic              decValid,
  output logic              claim,
  output logic              fwdUp,
  output logic              prefetchOk
);
  ctlStrobe_t strobe;

  mwin_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .addrValid(addrValid),
    .strobe   (strobe),
    .decValid (decValid)
  );

  mwin_dpath #(.DATA_W(DATA_W), .GRAN_BITS(GRAN_BITS)) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wrData    (wrData),
    .addr      (addr),
    .dualCycle (dualCycle),
    .cmdClass  (cmdClass),
    .fromDown  (fromDown),
    .claim     (claim),
    .fwdUp     (fwdUp),
    .prefetchOk(prefetchOk)
  );

  // R12
  out_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim || fwdUp || prefetchOk) |-> decValid);

  // R4
  up_implies_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwdUp |-> claim);
endmodule

// File: tb/mwin_fwd_decode_tb_top.sv
`timescale 1ns/100ps
module mwin_fwd_decode_tb_top;
  localparam logic [1:0] OTH = 2'b00, WR = 2'b01, RD = 2'b10, RDB = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic        addrValid = 1'b0;
  logic [63:0] addr = '0;
  logic        dualCycle = 1'b0;
  logic [1:0]  cmdClass = OTH;
  logic        fromDown = 1'b0;
  logic        decValid, claim, fwdUp, prefetchOk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mwin_fwd_decode dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .addrValid(addrValid), .addr(addr), .dualCycle(dualCycle),
    .cmdClass(cmdClass), .fromDown(fromDown), .decValid(decValid),
    .claim(claim), .fwdUp(fwdUp), .prefetchOk(prefetchOk)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic drive(input logic [63:0] a, input logic dual, input logic [1:0] cmd, input logic down);
    addr = a; dualCycle = dual; cmdClass = cmd; fromDown = down; addrValid = 1'b1;
  endtask

  task automatic expect3(input string tag, input logic eC, input logic eU, input logic eP);
    chk(tag, "decValid", decValid, 1'b1);
    chk(tag, "claim", claim, eC);
    chk(tag, "fwdUp", fwdUp, eU);
    chk(tag, "prefetchOk", prefetchOk, eP);
  endtask

  task automatic probe(input string tag, input logic [63:0] a, input logic dual,
                       input logic [1:0] cmd, input logic down,
                       input logic eC, input logic eU, input logic eP);
    @(negedge clk);
    drive(a, dual, cmd, down);
    @(negedge clk);
    addrValid = 1'b0;
    expect3(tag, eC, eU, eP);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R13", "decValid", decValid, 1'b0);
    chk("R13", "claim", claim, 1'b0);
    chk("R13", "fwdUp", fwdUp, 1'b0);
    chk("R13", "prefetchOk", prefetchOk, 1'b0);
    probe("R13 pf disabled up", 64'h0, 1'b0, RD, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R13 vga off down", 64'hA0000, 1'b0, RD, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_dual64();
    wr(3'd0, 32'h0000_0000); wr(3'd1, 32'h1);
    wr(3'd2, 32'h3FF0_0000); wr(3'd3, 32'h1);
    probe("R1 R5 dual hit up", 64'h1_2000_0000, 1'b1, RD, 1'b0, 1'b1, 1'b0, 1'b1);
    probe("R3 R5 dual above up", 64'h1_4000_0000, 1'b1, RD, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R2 dual hit down", 64'h1_2000_0000, 1'b1, WR, 1'b1, 1'b0, 1'b0, 1'b0);
    probe("R4 dual miss down", 64'h1_4000_0000, 1'b1, WR, 1'b1, 1'b1, 1'b1, 1'b0);
    probe("R6 single upper nonzero base", 64'h2000_0000, 1'b0, RD, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R5 dual other upper", 64'h2_2000_0000, 1'b1, RD, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_single();
    wr(3'd1, 32'h0); wr(3'd3, 32'h0);
    wr(3'd0, 32'h8000_0ABC); wr(3'd2, 32'h80F1_2345);
    probe("R8 base edge", 64'h8000_0000, 1'b0, RD, 1'b0, 1'b1, 1'b0, 1'b1);
    probe("R8 inclusive limit", 64'h80FF_FFFF, 1'b0, RD, 1'b0, 1'b1, 1'b0, 1'b1);
    probe("R8 above limit", 64'h8100_0000, 1'b0, RD, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R8 below base", 64'h7FFF_FFFF, 1'b0, RD, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R6 single junk upper", 64'hDEAD_BEEF_8000_0010, 1'b0, RD, 1'b0, 1'b1, 1'b0, 1'b1);
    probe("R5 dual junk upper", 64'hDEAD_BEEF_8000_0010, 1'b1, RD, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R7 write no prefetch", 64'h8000_0000, 1'b0, WR, 1'b0, 1'b1, 1'b0, 1'b0);
    probe("R7 block read", 64'h8040_0000, 1'b0, RDB, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_io_vga();
    wr(3'd4, 32'h9000_0000); wr(3'd5, 32'h9010_0000);
    probe("R10 io hit up", 64'h901F_FFFF, 1'b0, RD, 1'b0, 1'b1, 1'b0, 1'b0);
    probe("R4 io hit down", 64'h9000_0000, 1'b0, RD, 1'b1, 1'b0, 1'b0, 1'b0);
    probe("R3 io above up", 64'h9020_0000, 1'b0, RD, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R3 vga off up", 64'hA0000, 1'b0, RD, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(3'd6, 32'h1);
    probe("R10 vga hit up", 64'hBFFFF, 1'b0, WR, 1'b0, 1'b1, 1'b0, 1'b0);
    probe("R3 vga above up", 64'hC0000, 1'b0, WR, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R4 vga hit down", 64'hA0000, 1'b0, RD, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_disabled();
    wr(3'd0, 32'h8100_0000);
    probe("R9 inverted up", 64'h8080_0000, 1'b0, RD, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R9 inverted down", 64'h8080_0000, 1'b0, RD, 1'b1, 1'b1, 1'b1, 1'b0);
    wr(3'd0, 32'h8000_0000);
  endtask

  task automatic t_cmd();
    probe("R11 other in window up", 64'h8000_0000, 1'b0, OTH, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R11 other miss down", 64'h5000_0000, 1'b0, OTH, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_timing();
    probe("R12 pre", 64'h8080_0000, 1'b0, RD, 1'b0, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R12 idle", "decValid", decValid, 1'b0);
    chk("R12 idle", "claim", claim, 1'b0);
    chk("R12 idle", "prefetchOk", prefetchOk, 1'b0);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'd0; wrData = 32'h8100_0000;
    drive(64'h8080_0000, 1'b0, RD, 1'b0);
    @(negedge clk);
    wrEn = 1'b0; addrValid = 1'b0;
    expect3("R12 same-cycle write old", 1'b1, 1'b0, 1'b1);
    probe("R12 next strobe new", 64'h8080_0000, 1'b0, RD, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(3'd0, 32'h8000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dual64();
    t_single();
    t_io_vga();
    t_disabled();
    t_cmd();
    t_timing();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R12 act=hung exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule